// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one WIDTH-bit integer by another over several clock cycles and returns a WIDTH-bit quotient and a WIDTH-bit remainder. It produces one quotient bit per clock. Remainder and quotient share a single 2*WIDTH-bit working register. Each cycle that register shifts left by one, the divisor is trial-subtracted from its upper half, and the new quotient bit enters at the bottom. When the trial difference is negative, the shifted value is kept unchanged, which restores it, and the bit is 0. Otherwise the difference replaces the upper half and the bit is 1.

A caller pulses `start` with the operands and a mode bit. `signed_mode` selects two's complement operands. In that mode the block divides the magnitudes and then sets the signs of the results. A zero divisor is caught when the request is accepted: no iterations run, and the answer comes back on the next cycle with `div_by_zero` raised.

The interface is plain control, not a stream. A request is taken on any clock edge where `start` is high and `busy` is low. Nothing is buffered, so a `start` seen while `busy` is high is dropped, and the caller must hold off until `busy` falls.

Top module: `seq_restoring_div`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `busy`, `done` and `div_by_zero` are 0 and `quotient` and `remainder` are 0.
- R2: With `signed_mode` = 0 and a nonzero divisor, the operands are unsigned. `quotient` is floor(dividend/divisor) and `remainder` is dividend − quotient·divisor. For example, 74 ÷ 8 gives quotient 9 and remainder 2. `done` is high in the cycle that follows the WIDTH-th clock edge after the edge that accepted `start`.
- R3: `done` is high for exactly one cycle per accepted request. `busy` is high from the cycle after acceptance up to, but not including, the `done` cycle, which is WIDTH cycles. `busy` and `done` are never both high.
- R4: A `start` that arrives while `busy` is high is ignored, and the running division finishes with its original operands.
- R5: With `signed_mode` = 1, the operands are two's complement. The quotient truncates toward zero and is negative when the operand signs differ. The remainder takes the sign of the dividend. A most-negative dividend divided by −1 returns the most-negative value (low WIDTH bits of the true result).
- R6: A zero divisor runs no iterations. `busy` stays 0 and `done` rises in the cycle after acceptance, with `div_by_zero` = 1, `quotient` all ones and `remainder` equal to the dividend. This holds in both modes.
- R7: `quotient`, `remainder` and `div_by_zero` change only on the edge that raises `done`, and hold through all other cycles.
- R8: In unsigned mode, every completed nonzero-divisor result has `remainder` < divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; taken when `busy` is low |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend, sampled at acceptance |
| divisor | input | WIDTH | Divisor, sampled at acceptance |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WIDTH | Quotient, held until the next completion |
| remainder | output | WIDTH | Remainder, held until the next completion |
| div_by_zero | output | 1 | Last completed request had a zero divisor |

## Verification
The checker's latency and remainder-bound properties assume the operands are read only on the accepting edge, so it keeps its own copy of the divisor and mode taken at that edge. It also assumes every request is counted from an edge where `busy` is low. The bench drives `start` and the operands on falling edges and lowers `start` one cycle after acceptance. Its one deliberate overlap, a second `start` raised mid-run, falls inside the busy window, so the checker's captured copy is never overwritten by a request the block drops.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_sign_prep.sv
// Turns operands into magnitudes and records which results need negating.
module rdiv_sign_prep #(
  parameter int WIDTH = 8
) (
  input  logic             signed_mode,
  input  logic [WIDTH-1:0] num,
  input  logic [WIDTH-1:0] den,
  output logic [WIDTH-1:0] num_mag,
  output logic [WIDTH-1:0] den_mag,
  output logic             flip_quo,
  output logic             flip_rem
);
  logic num_neg, den_neg;

  always_comb begin
    num_neg  = signed_mode & num[WIDTH-1];
    den_neg  = signed_mode & den[WIDTH-1];
    num_mag  = num_neg ? (~num + 1'b1) : num;
    den_mag  = den_neg ? (~den + 1'b1) : den;
    flip_quo = num_neg ^ den_neg;
    flip_rem = num_neg;
  end
endmodule

// File: rtl/rdiv_step.sv
// One shift / trial-subtract / restore step on the shared register.
module rdiv_step #(
  parameter int WIDTH = 8
) (
  input  logic [2*WIDTH-1:0] acc,
  input  logic [WIDTH-1:0]   dvs,
  output logic [2*WIDTH-1:0] acc_nxt
);
  // upper half after the shift needs WIDTH+1 bits; one more bit holds the borrow
  logic [WIDTH+1:0] trial;

  always_comb begin
    trial = {1'b0, acc[2*WIDTH-1:WIDTH-1]} - {2'b00, dvs};
    if (trial[WIDTH+1]) begin
      acc_nxt = {acc[2*WIDTH-2:0], 1'b0};
    end else begin
      acc_nxt = {trial[WIDTH-1:0], acc[WIDTH-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/rdiv_sign_fix.sv
// Applies the recorded signs to the magnitude results.
module rdiv_sign_fix #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] quo_mag,
  input  logic [WIDTH-1:0] rem_mag,
  input  logic             flip_quo,
  input  logic             flip_rem,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem
);
  always_comb begin
    quo = flip_quo ? (~quo_mag + 1'b1) : quo_mag;
    rem = flip_rem ? (~rem_mag + 1'b1) : rem_mag;
  end
endmodule

// File: rtl/seq_restoring_div.sv
module seq_restoring_div #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             signed_mode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);
  import rdiv_pkg::*;

  localparam int CW   = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam int ACCW = 2 * WIDTH;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  rdiv_state_e      state;
  logic [CW-1:0]    step_cnt;
  logic [ACCW-1:0]  acc, acc_nxt;
  logic [WIDTH-1:0] dvs_r;
  logic             flip_quo_r, flip_rem_r;

  logic [WIDTH-1:0] num_mag, den_mag;
  logic             flip_quo_in, flip_rem_in;
  logic [WIDTH-1:0] quo_fixed, rem_fixed;
  logic             accept;

  rdiv_sign_prep #(.WIDTH(WIDTH)) u_prep (
    .signed_mode (signed_mode),
    .num         (dividend),
    .den         (divisor),
    .num_mag     (num_mag),
    .den_mag     (den_mag),
    .flip_quo    (flip_quo_in),
    .flip_rem    (flip_rem_in)
  );

  rdiv_step #(.WIDTH(WIDTH)) u_step (
    .acc     (acc),
    .dvs     (dvs_r),
    .acc_nxt (acc_nxt)
  );

  rdiv_sign_fix #(.WIDTH(WIDTH)) u_fix (
    .quo_mag  (acc_nxt[WIDTH-1:0]),
    .rem_mag  (acc_nxt[ACCW-1:WIDTH]),
    .flip_quo (flip_quo_r),
    .flip_rem (flip_rem_r),
    .quo      (quo_fixed),
    .rem      (rem_fixed)
  );

  assign busy   = (state == ST_RUN);
  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      step_cnt    <= '0;
      acc         <= '0;
      dvs_r       <= '0;
      flip_quo_r  <= 1'b0;
      flip_rem_r  <= 1'b0;
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (divisor == '0) begin
              done        <= 1'b1;
              div_by_zero <= 1'b1;
              quotient    <= '1;
              remainder   <= dividend;
            end else begin
              state      <= ST_RUN;
              step_cnt   <= '0;
              acc        <= {{WIDTH{1'b0}}, num_mag};
              dvs_r      <= den_mag;
              flip_quo_r <= flip_quo_in;
              flip_rem_r <= flip_rem_in;
            end
          end
        end
        ST_RUN: begin
          acc      <= acc_nxt;
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST) begin
            state       <= ST_IDLE;
            done        <= 1'b1;
            div_by_zero <= 1'b0;
            quotient    <= quo_fixed;
            remainder   <= rem_fixed;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             signed_mode,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             div_by_zero
);
  localparam int RCW = $clog2(WIDTH + 2);

  logic [WIDTH-1:0] dvs_c;
  logic             sm_c, zero_c;
  logic [RCW-1:0]   run_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvs_c  <= '0;
      sm_c   <= 1'b0;
      zero_c <= 1'b0;
      run_c  <= '0;
    end else if (start && !busy) begin
      dvs_c  <= divisor;
      sm_c   <= signed_mode;
      zero_c <= (divisor == '0);
      run_c  <= '0;
    end else if (busy) begin
      run_c  <= run_c + 1'b1;
    end
  end

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (run_c == RCW'(WIDTH)));

  a_r6_zero_no_iter: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (run_c == '0 && zero_c));

  a_r8_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero && !sm_c) |-> (remainder < dvs_c));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

  a_r4_busy_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind seq_restoring_div rdiv_checker #(.WIDTH(WIDTH)) u_rdiv_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .signed_mode (signed_mode),
  .divisor     (divisor),
  .busy        (busy),
  .done        (done),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_by_zero (div_by_zero)
);

// File: tb/tb_seq_restoring_div.sv
module tb_seq_restoring_div;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         signed_mode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  seq_restoring_div #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // One request, full timing and value check; optional mid-run start (R4)
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic sm, input string req, input bit poke);
    logic [31:0] eq, er;
    int sa, sb, cyc, busy_cyc;
    bit seen;
    if (b == '0) begin
      eq = {32{1'b1}};
      er = {24'd0, a};
    end else if (sm) begin
      sa = $signed(a);
      sb = $signed(b);
      eq = sa / sb;
      er = sa % sb;
    end else begin
      eq = a / b;
      er = a % b;
    end
    @(negedge clk);
    dividend = a; divisor = b; signed_mode = sm; start = 1'b1;
    cyc = 0; busy_cyc = 0; seen = 0;
    while (!seen && cyc < W + 6) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) start = 1'b0;
      if (poke && cyc == 3) begin
        start = 1'b1; dividend = 8'd3; divisor = 8'd1; signed_mode = 1'b0;
      end
      if (poke && cyc == 4) start = 1'b0;
      if (busy) busy_cyc++;
      if (done) seen = 1;
    end
    chk(req, "done latency", cyc, (b == '0) ? 1 : W + 1);
    chk("R3", "busy cycles", busy_cyc, (b == '0) ? 0 : W);
    chk(req, "quotient", {24'd0, quotient}, {24'd0, eq[W-1:0]});
    chk(req, "remainder", {24'd0, remainder}, {24'd0, er[W-1:0]});
    chk((b == '0) ? "R6" : req, "div_by_zero", div_by_zero, (b == '0));
    @(negedge clk);
    chk("R3", "done single pulse", done, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "dbz in reset", div_by_zero, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "quotient after reset", quotient, 0);
    chk("R1", "remainder after reset", remainder, 0);
    chk("R1", "busy after reset", busy, 0);
  endtask

  task automatic t_unsigned_directed();
    run_div(8'd74, 8'd8, 0, "R2", 0);
    run_div(8'd255, 8'd1, 0, "R2", 0);
    run_div(8'd0, 8'd5, 0, "R2", 0);
    run_div(8'd7, 8'd255, 0, "R2", 0);
    run_div(8'd255, 8'd255, 0, "R2", 0);
    run_div(8'd200, 8'd13, 0, "R8", 0);
  endtask

  task automatic t_signed_corners();
    run_div(8'h80, 8'hFF, 1, "R5", 0);
    run_div(8'hF9, 8'd2, 1, "R5", 0);
    run_div(8'd7, 8'hFE, 1, "R5", 0);
    run_div(8'hF9, 8'hFE, 1, "R5", 0);
    run_div(8'h80, 8'd1, 1, "R5", 0);
    run_div(8'h7F, 8'h80, 1, "R5", 0);
  endtask

  task automatic t_zero_divisor();
    run_div(8'd99, 8'd0, 0, "R6", 0);
    run_div(8'h85, 8'd0, 1, "R6", 0);
  endtask

  task automatic t_busy_start();
    run_div(8'd100, 8'd7, 0, "R4", 1);
    run_div(8'hC4, 8'd9, 1, "R4", 1);
  endtask

  task automatic t_hold();
    logic [W-1:0] q0, r0;
    run_div(8'd77, 8'd6, 0, "R7", 0);
    q0 = quotient; r0 = remainder;
    dividend = 8'd1; divisor = 8'd0; signed_mode = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7", "quotient held", quotient, q0);
    chk("R7", "remainder held", remainder, r0);
    chk("R7", "dbz held", div_by_zero, 0);
    run_div(8'd5, 8'd0, 0, "R6", 0);
    repeat (4) @(negedge clk);
    chk("R7", "dbz held high", div_by_zero, 1);
  endtask

  task automatic t_sweep();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      v = rnd();
      run_div(v[15:8], (v[23:16] == 0) ? 8'd3 : v[23:16], v[24],
              v[24] ? "R5" : "R2", 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_unsigned_directed();
    t_signed_corners();
    t_zero_divisor();
    t_busy_start();
    t_hold();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule